// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block is a per-lane test source for a serial link. Each clock it can hand a 32-bit parallel word to the serializer. The word holds either a repeated 16-bit programmable pattern or a slice of a pseudo-random bit sequence. The sequence length is picked at run time from eight polynomial orders, the longest being 63. In pattern mode, an optional DC-balance feature sends every second 16-bit symbol bitwise inverted. A separate polarity control inverts every bit that the block sends.

The output is a valid/ready stream.

- **Accepting a word:** a word is accepted on any rising edge where `out_valid` and `out_ready` are both high.
- **Back-pressure:** while `out_valid` is high and `out_ready` is low, the word and `out_valid` are held.
- **Disable:** dropping `enable` withdraws `out_valid` on the next edge. `out_data` keeps its last value, and generation pauses without losing its place.
- **Configuration changes:** changing the mode or the order restarts the generator from its seed. It also withdraws `out_valid` for one cycle. Pattern, DC-balance and polarity inputs take effect on the next word loaded. They should be changed only while no word is stalled.

Top module: `lane_pattern_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is all zeros until a word is loaded.
- R2: With `cfg_mode`=0 (pattern) and `cfg_alt_inv`=0, every word is `{cfg_pattern, cfg_pattern}`.
- R3: With `cfg_mode`=0 and `cfg_alt_inv`=1, symbols alternate between the pattern and its inverse. The low half, bits [15:0], carries the non-inverted symbol first. The phase continues across words and restarts at non-inverted after a mode or order change.
- R4: With `cfg_mode`=1, the block emits the sequence x^n+x^t+1, where `cfg_order` selects (n,t):
  - 0: (7,6)
  - 1: (9,5)
  - 2: (11,9)
  - 3: (15,14)
  - 4: (23,18)
  - 5: (31,28)
  - 6: (58,39)
  - 7: (63,62)

  The sequence comes from a state seeded with all ones. Each bit step forms fb = s[n-1]^s[t-1], shifts s left with fb entering at bit 0, and emits fb. Bit 0 of a word is the first bit emitted.
- R5: With `cfg_invert`=1, each loaded word is the bitwise inverse of the word it would otherwise be.
- R6: When `enable` is low, `out_valid` is 0 from the next edge and `out_data` holds. On resuming, the sequence continues from the next unsent word.
- R7: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold. The next word appears only after a handshake.
- R8: A change of `cfg_mode` or `cfg_order` drives `out_valid` low for the following cycle. The next word is the first word from the seed.
- R9: The pattern repeats with period 2^n−1 bits. For order 0 the 128th word after a restart equals the first. For order 1 the 512th equals the first.
- R10: `out_valid` rises on the first edge at which `enable` is high, unless a reconfiguration is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control for word generation |
| cfg_mode | input | 1 | 0 = programmable pattern, 1 = pseudo-random sequence |
| cfg_order | input | 3 | Polynomial order select (see R4) |
| cfg_pattern | input | 16 | Programmable 16-bit symbol |
| cfg_alt_inv | input | 1 | Invert every second symbol in pattern mode |
| cfg_invert | input | 1 | Invert all transmitted bits |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Parallel output word, bit 0 first on the line |
| out_valid | output | 1 | Word on `out_data` is valid |

## Verification
Every result comes from a single register stage. A word loaded on an edge is visible right after that edge. The withdrawal of `out_valid` after a disable or a mode or order change is also visible right after the edge that sees the input. The first seeded word follows one edge later. The bench drives inputs on falling edges and samples on the next falling edge, so each check observes exactly the edge that the requirement names. After a reconfiguration the bench expects one idle sample, then the seeded words in order.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  localparam int LFSR_W = 63;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRBS = 1'b1
  } lpg_mode_e;

  typedef struct packed {
    logic [5:0] hi;
    logic [5:0] lo;
  } lpg_taps_t;

  // Feedback taps (n, t) for x^n + x^t + 1, indexed by order select
  function automatic lpg_taps_t order_taps(input logic [2:0] sel);
    lpg_taps_t t;
    case (sel)
      3'd0:    t = '{hi: 6'd7,  lo: 6'd6};
      3'd1:    t = '{hi: 6'd9,  lo: 6'd5};
      3'd2:    t = '{hi: 6'd11, lo: 6'd9};
      3'd3:    t = '{hi: 6'd15, lo: 6'd14};
      3'd4:    t = '{hi: 6'd23, lo: 6'd18};
      3'd5:    t = '{hi: 6'd31, lo: 6'd28};
      3'd6:    t = '{hi: 6'd58, lo: 6'd39};
      default: t = '{hi: 6'd63, lo: 6'd62};
    endcase
    return t;
  endfunction

  // Mask covering the live low bits of the state for a given length
  function automatic logic [LFSR_W-1:0] live_mask(input logic [5:0] len);
    logic [LFSR_W-1:0] m;
    for (int i = 0; i < LFSR_W; i++) begin
      m[i] = (i < int'(len));
    end
    return m;
  endfunction

endpackage

// File: rtl/lpg_lfsr_adv.sv
module lpg_lfsr_adv #(
  parameter int STATE_W = 63,
  parameter int STEPS   = 32
) (
  input  logic [STATE_W-1:0] state_in,
  input  logic [5:0]         tap_hi,
  input  logic [5:0]         tap_lo,
  output logic [STATE_W-1:0] state_out,
  output logic [STEPS-1:0]   bits_out
);

  // Unrolled serial advance: one feedback bit per step, first bit in bit 0
  always_comb begin
    logic [STATE_W-1:0] s;
    logic               fb;
    s        = state_in;
    bits_out = '0;
    for (int i = 0; i < STEPS; i++) begin
      fb          = s[tap_hi - 6'd1] ^ s[tap_lo - 6'd1];
      s           = {s[STATE_W-2:0], fb};
      bits_out[i] = fb;
    end
    state_out = s;
  end

endmodule

// File: rtl/lpg_user_word.sv
module lpg_user_word #(
  parameter int SYM_W = 16,
  parameter int NSYM  = 2
) (
  input  logic [SYM_W-1:0]      pattern,
  input  logic                  alt_en,
  input  logic                  phase_in,
  output logic [SYM_W*NSYM-1:0] word,
  output logic                  phase_out
);

  localparam logic PHASE_FLIP = ((NSYM % 2) == 1);

  for (genvar k = 0; k < NSYM; k++) begin : g_sym
    localparam logic ODD = ((k % 2) == 1);
    assign word[k*SYM_W +: SYM_W] = pattern ^ {SYM_W{alt_en & (phase_in ^ ODD)}};
  end

  assign phase_out = phase_in ^ PHASE_FLIP;

endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen
  import lpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYM_W  = 16,
  parameter int ORD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_mode,
  input  logic [ORD_W-1:0]  cfg_order,
  input  logic [SYM_W-1:0]  cfg_pattern,
  input  logic              cfg_alt_inv,
  input  logic              cfg_invert,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  localparam int NSYM = DATA_W / SYM_W;
  localparam logic [LFSR_W-1:0] SEED = '1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              phase_q;
  logic              mode_q;
  logic [ORD_W-1:0]  order_q;

  lpg_taps_t         taps;
  logic [LFSR_W-1:0] mask;
  logic [LFSR_W-1:0] state_live;
  logic [LFSR_W-1:0] state_next;
  logic [DATA_W-1:0] prbs_word;
  logic [DATA_W-1:0] user_word;
  logic              phase_next;
  logic [DATA_W-1:0] raw_word;
  logic              cfg_change;
  logic              load;
  logic              is_prbs;

  assign taps       = order_taps(3'(cfg_order));
  assign mask       = live_mask(taps.hi);
  // A zero live state cannot advance; fall back to the seed
  assign state_live = ((lfsr_q & mask) == '0) ? SEED : lfsr_q;
  assign is_prbs    = (lpg_mode_e'(cfg_mode) == MODE_PRBS);
  assign cfg_change = (cfg_mode != mode_q) || (cfg_order != order_q);
  assign load       = enable && !cfg_change && (!valid_q || out_ready);

  lpg_lfsr_adv #(
    .STATE_W (LFSR_W),
    .STEPS   (DATA_W)
  ) u_adv (
    .state_in  (state_live),
    .tap_hi    (taps.hi),
    .tap_lo    (taps.lo),
    .state_out (state_next),
    .bits_out  (prbs_word)
  );

  lpg_user_word #(
    .SYM_W (SYM_W),
    .NSYM  (NSYM)
  ) u_user (
    .pattern   (cfg_pattern),
    .alt_en    (cfg_alt_inv),
    .phase_in  (phase_q),
    .word      (user_word),
    .phase_out (phase_next)
  );

  assign raw_word = is_prbs ? prbs_word : user_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= SEED;
      data_q  <= '0;
      valid_q <= 1'b0;
      phase_q <= 1'b0;
      mode_q  <= 1'b0;
      order_q <= '0;
    end else begin
      mode_q  <= cfg_mode;
      order_q <= cfg_order;
      if (cfg_change) begin
        lfsr_q  <= SEED;
        phase_q <= 1'b0;
        valid_q <= 1'b0;
      end else if (!enable) begin
        valid_q <= 1'b0;
      end else if (load) begin
        data_q  <= raw_word ^ {DATA_W{cfg_invert}};
        valid_q <= 1'b1;
        if (is_prbs) lfsr_q  <= state_next;
        else         phase_q <= phase_next;
      end
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/lpg_chk.sv
module lpg_chk #(
  parameter int DATA_W = 32,
  parameter int ORD_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cfg_mode,
  input logic [ORD_W-1:0]  cfg_order,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid
);

  // R6
  disable_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_valid);

  // R6
  disable_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(out_data));

  // R7
  stall_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R7
  stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && enable && $stable(cfg_mode) && $stable(cfg_order))
      |=> (out_valid || !enable || !$stable(cfg_mode) || !$stable(cfg_order)));

  // R8
  reconfig_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_mode) || !$stable(cfg_order)) |=> !out_valid);

  // R10
  valid_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(enable));

endmodule

bind lane_pattern_gen lpg_chk #(
  .DATA_W (DATA_W),
  .ORD_W  (ORD_W)
) u_lpg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cfg_mode  (cfg_mode),
  .cfg_order (cfg_order),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/tb_lane_pattern_gen.sv
`timescale 1ns/1ps
module tb_lane_pattern_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [2:0]  cfg_order = 3'd0;
  logic [15:0] cfg_pattern = 16'h0000;
  logic        cfg_alt_inv = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [62:0] mst;
  int          m_hi;
  int          m_lo;
  logic [31:0] cap [0:511];

  always #2 clk = ~clk;

  lane_pattern_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cfg_mode    (cfg_mode),
    .cfg_order   (cfg_order),
    .cfg_pattern (cfg_pattern),
    .cfg_alt_inv (cfg_alt_inv),
    .cfg_invert  (cfg_invert),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_valid   (out_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Polynomial table written from R4
  task automatic model_seed(input int sel);
    case (sel)
      0: begin m_hi = 7;  m_lo = 6;  end
      1: begin m_hi = 9;  m_lo = 5;  end
      2: begin m_hi = 11; m_lo = 9;  end
      3: begin m_hi = 15; m_lo = 14; end
      4: begin m_hi = 23; m_lo = 18; end
      5: begin m_hi = 31; m_lo = 28; end
      6: begin m_hi = 58; m_lo = 39; end
      default: begin m_hi = 63; m_lo = 62; end
    endcase
    mst = '1;
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    logic        fb;
    for (int i = 0; i < 32; i++) begin
      fb   = mst[m_hi-1] ^ mst[m_lo-1];
      mst  = {mst[61:0], fb};
      w[i] = fb;
    end
    return w;
  endfunction

  // Change mode/order, expect one idle sample, leave bench on the first seeded word
  task automatic reconfig(input logic mode, input int sel, input logic inv, input string req);
    @(negedge clk);
    cfg_mode   = mode;
    cfg_order  = 3'(sel);
    cfg_invert = inv;
    @(negedge clk);
    chk(req, {31'd0, out_valid}, 32'd0);
    model_seed(sel);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 data in reset", out_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 data after reset", out_data, 32'd0);
  endtask

  task automatic t_user_plain();
    cfg_pattern = 16'hA35C;
    enable = 1'b1;
    @(negedge clk);
    chk("R10 valid one edge after enable", {31'd0, out_valid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      chk("R2 plain pattern", out_data, {16'hA35C, 16'hA35C});
      @(negedge clk);
    end
    cfg_pattern = 16'h0F01;
    @(negedge clk);
    chk("R2 new pattern", out_data, {16'h0F01, 16'h0F01});
  endtask

  task automatic t_user_alt();
    cfg_alt_inv = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk("R3 alternate inversion", out_data, {~16'h0F01, 16'h0F01});
      @(negedge clk);
    end
    cfg_invert = 1'b1;
    @(negedge clk);
    chk("R5 polarity on pattern", out_data, ~{~16'h0F01, 16'h0F01});
    cfg_invert  = 1'b0;
    cfg_alt_inv = 1'b0;
  endtask

  task automatic t_prbs_orders();
    for (int s = 0; s < 8; s++) begin
      reconfig(1'b1, s, 1'b0, "R8 idle after order change");
      for (int w = 0; w < 4; w++) begin
        chk("R4 sequence word", out_data, model_word());
        if (w < 3) @(negedge clk);
      end
    end
  endtask

  task automatic t_period();
    reconfig(1'b1, 0, 1'b0, "R8 idle before period 7");
    for (int i = 0; i < 128; i++) begin
      cap[i] = out_data;
      @(negedge clk);
    end
    chk("R9 period 127 bits", cap[127], cap[0]);
    chk("R9 not constant", {31'd0, (cap[1] != cap[0])}, 32'd1);
    reconfig(1'b1, 1, 1'b0, "R8 idle before period 9");
    for (int i = 0; i < 512; i++) begin
      cap[i] = out_data;
      if (i < 511) @(negedge clk);
    end
    chk("R9 period 511 bits", cap[511], cap[0]);
  endtask

  task automatic t_polarity();
    reconfig(1'b1, 2, 1'b1, "R8 idle before polarity");
    for (int w = 0; w < 4; w++) begin
      chk("R5 inverted sequence", out_data, ~model_word());
      @(negedge clk);
    end
  endtask

  task automatic t_enable_gap();
    logic [31:0] last;
    reconfig(1'b1, 3, 1'b0, "R8 idle before enable gap");
    chk("R4 order 3 word 0", out_data, model_word());
    @(negedge clk);
    last = model_word();
    chk("R4 order 3 word 1", out_data, last);
    enable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 valid low when disabled", {31'd0, out_valid}, 32'd0);
      chk("R6 data held when disabled", out_data, last);
    end
    enable = 1'b1;
    @(negedge clk);
    chk("R10 valid back after enable", {31'd0, out_valid}, 32'd1);
    chk("R6 sequence resumes", out_data, model_word());
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    @(negedge clk);
    held = model_word();
    chk("R4 word before stall", out_data, held);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 data held in stall", out_data, held);
      chk("R7 valid held in stall", {31'd0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 next word after handshake", out_data, model_word());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_user_plain();
    t_user_alt();
    t_prbs_orders();
    t_period();
    t_polarity();
    t_enable_gap();
    t_backpressure();
    reconfig(1'b0, 0, 1'b0, "R8 idle on return to pattern mode");
    chk("R2 pattern after mode return", out_data, {16'h0F01, 16'h0F01});
    finish_run();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule